// File: doc/BRIEF.md
# Time-Sliced Bus Request/Grant Arbiter

This block decides which of several initiators on a shared parallel bus (PCI-style, with active-low request and grant lines) may drive the bus next. Once an initiator owns the bus, it keeps its grant for a programmable time slice. Within that slice it can run several short back-to-back transactions without losing the bus to competing requesters. When the slice has run out and someone else is waiting, the arbiter takes the grant away at the next idle bus cycle and passes it on.

The slice length is held in an 8-bit register that can be written and read back. It counts bus clocks in steps of eight, and a value of zero turns the slice limit off. A mode input chooses between a fair rotation among all initiators and a mode in which initiator 0 is preferred whenever the grant moves. The arbiter watches the FRAME# and IRDY# lines so that it only moves the grant while the bus is idle. It always leaves one clock with no grant asserted between two different owners. When nobody is requesting, the grant stays with the last owner.

Top module: `bus_slice_arbiter`

## Requirements
- R1: After reset, the grant is parked on initiator 0 (`gnt_n` = 4'b1110 for four initiators) and the slice register reads 20h.
- R2: A write to the slice register stores the value with bits [2:0] forced to zero. The stored value is visible on `tmr_rd_data` one clock after the write cycle (a write of 1Fh reads back as 18h).
- R3: With a nonzero slice of S clocks, an owner that keeps requesting while another initiator requests and the bus stays idle holds its grant for exactly S+1 clocks, counted from the first clock the grant is visible.
- R4: With a slice value of 00h, an owner that keeps requesting never loses its grant, even while other initiators request.
- R5: When the slice expires and no other initiator is requesting, the owner keeps its grant and a new slice starts.
- R6: With `prio_hi_en` = 0, each new owner is the first requester found by stepping upward (with wrap) from the previous owner, excluding the previous owner.
- R7: With `prio_hi_en` = 1, whenever the grant moves away from an owner other than initiator 0 and request 0 is asserted, initiator 0 receives the next grant.
- R8: The grant is only withdrawn in a clock where `frame_n` and `irdy_n` are both high. While either line is low, the grant stays unchanged.
- R9: Between the grants of two different initiators, there is at least one clock in which every `gnt_n` bit is high.
- R10: While no request is asserted, the current grant stays where it is.
- R11: When the owner drops its request while the bus is idle and another initiator requests, the grant is withdrawn on the next clock and the new owner's grant appears one clock after that.
- R12: At most one `gnt_n` bit is low in any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | N_INIT | Request lines, active low, one per initiator |
| frame_n | input | 1 | Bus FRAME#, active low; high with irdy_n high means idle |
| irdy_n | input | 1 | Bus IRDY#, active low |
| prio_hi_en | input | 1 | 1 = initiator 0 preferred, 0 = fair rotation |
| tmr_wr_en | input | 1 | Write strobe for the slice register |
| tmr_wr_data | input | 8 | Slice value to write, in bus clocks |
| tmr_rd_data | output | 8 | Current slice register contents |
| gnt_n | output | N_INIT | Grant lines, active low, one per initiator |

## Verification
A corrupted slice counter shows up as a grant that lasts one or more clocks too long or too short. This is visible at the first contested handover after the fault, at most one slice later. A wrong owner index or a wrong rotation pointer appears as a wrong `gnt_n` pattern on the clock after the next dead cycle. A handover state that goes wrong shows at once, either as a missing dead clock or as a grant withdrawn while FRAME# or IRDY# is low. Because of this, a bench that compares every `gnt_n` value on every clock against an independent model catches all three kinds of fault within one slice.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int unsigned SLICE_W         = 8;
    localparam int unsigned SLICE_GRAN_BITS = 3;
    localparam logic [SLICE_W-1:0] SLICE_RST = 8'h20;

    typedef enum logic {
        PH_OWN = 1'b0,
        PH_GAP = 1'b1
    } arb_phase_e;

    typedef struct packed {
        logic load;
        logic reload;
        logic dec;
    } slice_ctl_t;

    function automatic logic [SLICE_W-1:0] quantize_slice(input logic [SLICE_W-1:0] v);
        logic [SLICE_W-1:0] r;
        r = v;
        r[SLICE_GRAN_BITS-1:0] = '0;
        return r;
    endfunction

endpackage

// File: rtl/arb_tmr_reg.sv
module arb_tmr_reg
    import arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SLICE_W-1:0] wr_data,
    output logic [SLICE_W-1:0] value
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= SLICE_RST;
        end else if (wr_en) begin
            value <= quantize_slice(wr_data);
        end
    end

endmodule

// File: rtl/arb_slice_cnt.sv
module arb_slice_cnt
    import arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  slice_ctl_t         ctl,
    input  logic [SLICE_W-1:0] slice,
    output logic               expired
);

    logic [SLICE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= SLICE_RST;
        end else if (ctl.load || ctl.reload) begin
            cnt <= slice;
        end else if (ctl.dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    // A zero slice disables expiry altogether
    assign expired = (slice != '0) && (cnt == '0);

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int unsigned N_INIT = 4,
    localparam int unsigned IDX_W = (N_INIT > 1) ? $clog2(N_INIT) : 1
) (
    input  logic [N_INIT-1:0] req,
    input  logic [IDX_W-1:0]  owner,
    input  logic              prio_hi,
    output logic              any_other,
    output logic [IDX_W-1:0]  pick
);

    logic [N_INIT-1:0] others;

    generate
        for (genvar g = 0; g < N_INIT; g++) begin : g_mask
            assign others[g] = req[g] && (owner != IDX_W'(g));
        end
    endgenerate

    assign any_other = |others;

    always_comb begin
        pick = owner;
        // descending scan so the nearest successor is written last
        for (int k = N_INIT - 1; k >= 1; k--) begin
            int idx;
            idx = (int'(owner) + k) % int'(N_INIT);
            if (others[idx]) begin
                pick = IDX_W'(idx);
            end
        end
        if (prio_hi && others[0]) begin
            pick = '0;
        end
    end

endmodule

// File: rtl/bus_slice_arbiter.sv
module bus_slice_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned N_INIT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_INIT-1:0]  req_n,
    input  logic               frame_n,
    input  logic               irdy_n,
    input  logic               prio_hi_en,
    input  logic               tmr_wr_en,
    input  logic [SLICE_W-1:0] tmr_wr_data,
    output logic [SLICE_W-1:0] tmr_rd_data,
    output logic [N_INIT-1:0]  gnt_n
);

    localparam int unsigned IDX_W = (N_INIT > 1) ? $clog2(N_INIT) : 1;

    arb_phase_e         phase;
    logic [IDX_W-1:0]   owner;
    logic [IDX_W-1:0]   pick;
    logic [N_INIT-1:0]  req_a;
    logic               any_other;
    logic               expired;
    logic               bus_idle;
    logic               owner_req;
    logic               handover;
    slice_ctl_t         ctl;

    assign req_a    = ~req_n;
    assign bus_idle = frame_n && irdy_n;

    always_comb begin
        owner_req = 1'b0;
        for (int i = 0; i < N_INIT; i++) begin
            if (owner == IDX_W'(i)) begin
                owner_req = req_a[i];
            end
        end
    end

    arb_tmr_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tmr_wr_en),
        .wr_data (tmr_wr_data),
        .value   (tmr_rd_data)
    );

    arb_pick #(.N_INIT(N_INIT)) u_pick (
        .req       (req_a),
        .owner     (owner),
        .prio_hi   (prio_hi_en),
        .any_other (any_other),
        .pick      (pick)
    );

    assign handover = (phase == PH_OWN) && bus_idle && any_other
                      && (!owner_req || expired);

    always_comb begin
        ctl        = '0;
        ctl.load   = (phase == PH_GAP);
        ctl.reload = (phase == PH_OWN) && !handover && expired && !any_other;
        ctl.dec    = (phase == PH_OWN) && !handover && !ctl.reload && owner_req;
    end

    arb_slice_cnt u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .slice   (tmr_rd_data),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_OWN;
            owner <= '0;
        end else begin
            unique case (phase)
                PH_OWN: begin
                    if (handover) begin
                        phase <= PH_GAP;
                        owner <= pick;
                    end
                end
                PH_GAP: phase <= PH_OWN;
                default: phase <= PH_OWN;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < N_INIT; g++) begin : g_gnt
            assign gnt_n[g] = !((phase == PH_OWN) && (owner == IDX_W'(g)));
        end
    endgenerate

endmodule

// File: rtl/arb_checker.sv
module arb_checker
    import arb_pkg::*;
#(
    parameter int unsigned N_INIT = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [N_INIT-1:0]  req_n,
    input logic               frame_n,
    input logic               irdy_n,
    input logic               prio_hi_en,
    input logic               tmr_wr_en,
    input logic [SLICE_W-1:0] tmr_wr_data,
    input logic [SLICE_W-1:0] tmr_rd_data,
    input logic [N_INIT-1:0]  gnt_n
);

    p_single_grant_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~gnt_n));

    p_dead_clock_r9: assert property (@(posedge clk) disable iff (rst)
        ((gnt_n != '1) && ($past(gnt_n) != '1)) |-> (gnt_n == $past(gnt_n)));

    p_idle_release_r8: assert property (@(posedge clk) disable iff (rst)
        ((gnt_n == '1) && ($past(gnt_n) != '1)) |-> ($past(frame_n) && $past(irdy_n)));

    p_park_r10: assert property (@(posedge clk) disable iff (rst)
        ((&$past(req_n)) && ($past(gnt_n) != '1)) |-> (gnt_n == $past(gnt_n)));

    p_prio_zero_r7: assert property (@(posedge clk) disable iff (rst)
        ((gnt_n == '1) && ($past(gnt_n) != '1) && $past(prio_hi_en)
         && !$past(req_n[0]) && $past(gnt_n[0])) |=> !gnt_n[0]);

    p_tmr_write_r2: assert property (@(posedge clk) disable iff (rst)
        tmr_wr_en |=> (tmr_rd_data == quantize_slice($past(tmr_wr_data))));

endmodule

bind bus_slice_arbiter arb_checker #(.N_INIT(N_INIT)) u_arb_checker (
    .clk         (clk),
    .rst         (rst),
    .req_n       (req_n),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .prio_hi_en  (prio_hi_en),
    .tmr_wr_en   (tmr_wr_en),
    .tmr_wr_data (tmr_wr_data),
    .tmr_rd_data (tmr_rd_data),
    .gnt_n       (gnt_n)
);

// File: tb/tb_bus_slice_arbiter.sv
`timescale 1ns/1ps
module tb_bus_slice_arbiter;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req_n;
    logic         frame_n;
    logic         irdy_n;
    logic         prio_hi_en;
    logic         tmr_wr_en;
    logic [7:0]   tmr_wr_data;
    logic [7:0]   tmr_rd_data;
    logic [N-1:0] gnt_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    bus_slice_arbiter #(.N_INIT(N)) dut (
        .clk(clk), .rst(rst), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .prio_hi_en(prio_hi_en), .tmr_wr_en(tmr_wr_en), .tmr_wr_data(tmr_wr_data),
        .tmr_rd_data(tmr_rd_data), .gnt_n(gnt_n)
    );

    // behavioural reference
    int m_owner, m_cnt, m_tmr;
    bit m_gr;

    function automatic int m_pick(logic [N-1:0] r, int own, bit pr);
        if (pr && r[0] && own != 0) return 0;
        for (int k = 1; k < N; k++) begin
            if (r[(own + k) % N]) return (own + k) % N;
        end
        return own;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_owner = 0; m_gr = 1; m_cnt = 32; m_tmr = 32;
        end else begin
            logic [N-1:0] r;
            logic [N-1:0] oth;
            bit exp_s, idle;
            r = ~req_n;
            oth = r;
            oth[m_owner] = 1'b0;
            exp_s = (m_tmr != 0) && (m_cnt == 0);
            idle = frame_n && irdy_n;
            if (m_gr) begin
                if (idle && (oth != 0) && (!r[m_owner] || exp_s)) begin
                    m_gr = 0;
                    m_owner = m_pick(r, m_owner, prio_hi_en);
                end else if (exp_s && oth == 0) begin
                    m_cnt = m_tmr;
                end else if (r[m_owner] && m_cnt > 0) begin
                    m_cnt = m_cnt - 1;
                end
            end else begin
                m_gr = 1;
                m_cnt = m_tmr;
            end
            if (tmr_wr_en) m_tmr = int'(tmr_wr_data & 8'hF8);
        end
    end

    task automatic check_eq(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", t, act, exp, cycles);
        end
    endtask

    function automatic int cur_owner();
        for (int i = 0; i < N; i++) if (!gnt_n[i]) return i;
        return -1;
    endfunction

    logic [N-1:0] prev_gnt = '1;
    always @(negedge clk) begin
        if (!rst) begin
            logic [N-1:0] exp_g;
            exp_g = '1;
            if (m_gr) exp_g[m_owner] = 1'b0;
            check_eq({tag, " grant vs model"}, int'(gnt_n), int'(exp_g));
            check_eq({tag, " slice reg vs model"}, int'(tmr_rd_data), m_tmr);
            check_eq("R12 at most one grant", $countones(~gnt_n) <= 1 ? 1 : 0, 1);
            check_eq("R9 dead clock",
                     (prev_gnt != '1 && gnt_n != '1 && gnt_n != prev_gnt) ? 0 : 1, 1);
        end
        prev_gnt = gnt_n;
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic wr_slice(logic [7:0] v);
        @(negedge clk); tmr_wr_en = 1'b1; tmr_wr_data = v;
        @(negedge clk); tmr_wr_en = 1'b0;
    endtask

    initial begin
        int n, last, ow, g0;
        rst = 1'b1; req_n = '1; frame_n = 1'b1; irdy_n = 1'b1;
        prio_hi_en = 1'b0; tmr_wr_en = 1'b0; tmr_wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        tag = "R1";
        check_eq("R1 reset grant", int'(gnt_n), 'hE);
        check_eq("R1 reset slice", int'(tmr_rd_data), 'h20);

        tag = "R10";
        repeat (8) @(negedge clk);
        check_eq("R10 parked on 0", int'(gnt_n), 'hE);

        tag = "R2";
        wr_slice(8'h1F);
        check_eq("R2 readback 1F", int'(tmr_rd_data), 'h18);

        tag = "R3";
        req_n = 4'b1010;
        n = 0;
        for (int i = 0; i < 200 && gnt_n[2]; i++) @(negedge clk);
        while (!gnt_n[2] && n < 200) begin n++; @(negedge clk); end
        check_eq("R3 grant length slice+1", n, 25);

        tag = "R8";
        repeat (3) @(negedge clk);
        req_n = 4'b0101;
        frame_n = 1'b0;
        g0 = int'(gnt_n);
        repeat (60) @(negedge clk);
        check_eq("R8 frame low holds grant", int'(gnt_n), g0);
        frame_n = 1'b1; irdy_n = 1'b0;
        repeat (30) @(negedge clk);
        check_eq("R8 irdy low holds grant", int'(gnt_n), g0);
        irdy_n = 1'b1;

        tag = "R6";
        req_n = '0;
        last = cur_owner();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            ow = cur_owner();
            if (ow >= 0 && last >= 0 && ow != last)
                check_eq("R6 rotation order", ow, (last + 1) % N);
            if (ow >= 0) last = ow;
        end

        tag = "R7";
        prio_hi_en = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            ow = cur_owner();
            if (ow >= 0 && last >= 0 && ow != last)
                check_eq("R7 initiator 0 preferred", ow, last != 0 ? 0 : ow);
            if (ow >= 0) last = ow;
        end
        prio_hi_en = 1'b0;

        tag = "R11";
        for (int i = 0; i < 200 && cur_owner() < 0; i++) @(negedge clk);
        ow = cur_owner();
        req_n = '1;
        req_n[(ow + 1) % N] = 1'b0;
        @(negedge clk);
        check_eq("R11 withdrawn next clock", int'(gnt_n), 'hF);
        @(negedge clk);
        check_eq("R11 new owner", cur_owner(), (ow + 1) % N);

        tag = "R5";
        req_n = '1;
        req_n[(ow + 1) % N] = 1'b0;
        g0 = int'(gnt_n);
        repeat (100) @(negedge clk);
        check_eq("R5 sole requester keeps grant", int'(gnt_n), g0);

        tag = "R4";
        wr_slice(8'h00);
        req_n = '0;
        g0 = int'(gnt_n);
        repeat (150) @(negedge clk);
        check_eq("R4 disabled slice keeps owner", int'(gnt_n), g0);

        tag = "R12";
        wr_slice(8'h20);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 7) == 0) req_n = N'($urandom);
            frame_n = ($urandom_range(0, 3) != 0);
            irdy_n  = ($urandom_range(0, 4) != 0);
            if ($urandom_range(0, 199) == 0) prio_hi_en = ~prio_hi_en;
            if ($urandom_range(0, 499) == 0) begin
                tmr_wr_en = 1'b1;
                tmr_wr_data = 8'($urandom_range(0, 8) * 8 + 17);
            end else begin
                tmr_wr_en = 1'b0;
            end
        end
        tmr_wr_en = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule